// File: doc/BRIEF.md
# MOSI Snooping Cache Line Controller

This block keeps the coherence state of every line in a small private, set-associative cache that sits on a snooped shared bus. It uses four line states: Modified, Owned, Shared and Invalid. It serves the local processor's reads and writes. It answers requests that other caches place on the bus, and it issues its own bus requests: shared read, exclusive read, invalidate and write-back. Only coherence state and tags are kept. The supply flag on a snoop answer stands for the data transfer.

A line that is dirty and read by another cache moves to Owned and keeps supplying data. Memory is not updated, so no write-back happens on that path. A write-back happens only when a dirty line (Modified or Owned) is chosen as the least-recently-used victim of a fill. Every local request carries a speculative flag, and that flag travels to the bus request and to the completion pulse. A request that is later squashed has the same lasting effect on line state as any other request. This makes the footprint of wrong-path accesses visible to the system.

The local request port is valid/ready. `cpu_ready` is low while the controller is busy, while a snoop is present, and during the cycle in which a snoop answer is given. The bus request port is valid/ready as well. Once `bus_req_valid` is raised, the operation, address and flag stay frozen until `bus_req_ready` is seen high at a clock edge. Snoops, bus responses and invalidation acknowledgements are plain pulses and cannot be stalled.

Top module: `mosi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid and `cpu_ready` is high. No bus request, no completion and no snoop answer is active. A snoop that arrives before any fill gets neither supply nor ack.
- R2: Bus operation codes, on both `bus_req_op` and `snp_op`, are: 0 shared read, 1 exclusive read, 2 invalidate, 3 write-back. A local read that misses issues code 0 and fills the line as Shared. A later snoop read of that line gets no supply.
- R3: A local write to an Invalid line issues code 1 and leaves the line Modified. A further write to that line completes with no bus request.
- R4: A snoop read (code 0) of a Modified or Owned line answers with supply and leaves the line Owned. No write-back is issued for it.
- R5: A local write to a Shared or Owned line issues code 2. The count in `bus_resp_acks` is latched with `bus_resp_valid`. `cpu_done` is withheld until that many `inv_ack` pulses have arrived, and the line then ends Modified.
- R6: A snoop exclusive read (code 1) or invalidate (code 2) that hits a valid line drops it to Invalid and answers with ack. An exclusive read also supplies from Modified or Owned. An invalidate never supplies.
- R7: A fill goes to the lowest Invalid way of the set, or else to the least-recently-used way. A Modified or Owned victim is first written back with code 3 at its own address, before the miss request. A Shared victim is dropped with no write-back, and the evicted line no longer answers snoops.
- R8: `cpu_spec` is carried to `bus_req_spec` and to `cpu_done_spec`. A speculative request changes line state exactly as a normal one does, and that change remains.
- R9: A snoop is answered on `snp_resp_valid` in the cycle after it is presented. `cpu_ready` is low in the snoop cycle and in the answer cycle.
- R10: While `bus_req_valid` is high and `bus_req_ready` is low, `bus_req_valid`, `bus_req_op` and `bus_req_addr` hold their values.
- R11: After a remote exclusive read or invalidate has removed a line, the controller never supplies that line until it writes the line again. At most one cache therefore holds a line dirty.
- R12: A local read that hits a valid line completes with no bus request. `cpu_done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Local request present |
| cpu_ready | output | 1 | Local request accepted at this edge if valid |
| cpu_write | input | 1 | Local request is a write |
| cpu_spec | input | 1 | Local request is speculative |
| cpu_addr | input | ADDR_W | Line address of local request |
| cpu_done | output | 1 | Local request completed (one-cycle pulse) |
| cpu_done_spec | output | 1 | Speculative flag of the completed request |
| bus_req_valid | output | 1 | Bus request present |
| bus_req_ready | input | 1 | Bus takes the request at this edge |
| bus_req_op | output | 2 | Bus operation code |
| bus_req_addr | output | ADDR_W | Line address of bus request |
| bus_req_spec | output | 1 | Speculative flag carried on the bus |
| bus_resp_valid | input | 1 | Response to the outstanding request |
| bus_resp_acks | input | ACK_W | Invalidation acknowledgements to await |
| inv_ack | input | 1 | One invalidation acknowledgement |
| snp_valid | input | 1 | Snooped request from another cache |
| snp_op | input | 2 | Snooped operation code |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_resp_valid | output | 1 | Snoop answer, cycle after the snoop |
| snp_supply | output | 1 | This cache supplies the line |
| snp_ack | output | 1 | This cache dropped a valid copy |

## Verification
A wrong line state becomes visible at the next access to that line. A snoop exposes it one cycle later through a missing or spurious supply or ack. A local access exposes it through the bus operation code it issues, or through a bus request that appears or is missing, within a few cycles of acceptance. A wrong replacement choice shows up as a write-back at the wrong address, or as a missing write-back ahead of the miss request. A premature upgrade shows up as `cpu_done` rising before the last acknowledgement.

// File: rtl/mosi_ctrl_pkg.sv
package mosi_ctrl_pkg;
  typedef enum logic [1:0] {LN_I = 2'd0, LN_S = 2'd1, LN_O = 2'd2, LN_M = 2'd3} line_st_e;
  typedef enum logic [1:0] {OP_RDSH = 2'd0, OP_RDEX = 2'd1, OP_INVAL = 2'd2, OP_WBACK = 2'd3} bus_op_e;
  typedef enum logic [2:0] {CS_IDLE, CS_LOOK, CS_WBACK, CS_REQ, CS_WAIT, CS_FILL} ctl_st_e;
  typedef struct packed {
    line_st_e nxt;
    logic     supply;
    logic     ack;
  } snoop_eff_t;
endpackage

// File: rtl/mosi_snoop_xlat.sv
module mosi_snoop_xlat
  import mosi_ctrl_pkg::*;
(
  input  line_st_e   cur,
  input  logic [1:0] op,
  output snoop_eff_t eff
);
  always_comb begin
    eff.nxt    = cur;
    eff.supply = 1'b0;
    eff.ack    = 1'b0;
    case (bus_op_e'(op))
      OP_RDSH: if (cur == LN_M || cur == LN_O) begin
        eff.nxt    = LN_O;
        eff.supply = 1'b1;
      end
      OP_RDEX: if (cur != LN_I) begin
        eff.supply = (cur == LN_M || cur == LN_O);
        eff.ack    = 1'b1;
        eff.nxt    = LN_I;
      end
      OP_INVAL: if (cur != LN_I) begin
        eff.ack = 1'b1;
        eff.nxt = LN_I;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mosi_line_store.sv
module mosi_line_store
  import mosi_ctrl_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int TAG_W = 6,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] a_idx,
  input  logic [TAG_W-1:0] a_tag,
  output logic             a_hit,
  output logic [WAY_W-1:0] a_way,
  output line_st_e         a_st,
  output logic [WAY_W-1:0] v_way,
  output line_st_e         v_st,
  output logic [TAG_W-1:0] v_tag,
  input  logic [IDX_W-1:0] b_idx,
  input  logic [TAG_W-1:0] b_tag,
  output logic             b_hit,
  output logic [WAY_W-1:0] b_way,
  output line_st_e         b_st,
  input  logic             we,
  input  logic [IDX_W-1:0] w_idx,
  input  logic [WAY_W-1:0] w_way,
  input  logic [TAG_W-1:0] w_tag,
  input  line_st_e         w_st,
  input  logic             touch,
  input  logic [IDX_W-1:0] t_idx,
  input  logic [WAY_W-1:0] t_way
);
  line_st_e         st_q  [SETS][WAYS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAY_W-1:0] age_q [SETS][WAYS];

  always_comb begin
    a_hit = 1'b0; a_way = '0; a_st = LN_I;
    b_hit = 1'b0; b_way = '0; b_st = LN_I;
    for (int w = 0; w < WAYS; w++) begin
      if (st_q[a_idx][w] != LN_I && tag_q[a_idx][w] == a_tag) begin
        a_hit = 1'b1; a_way = WAY_W'(w); a_st = st_q[a_idx][w];
      end
      if (st_q[b_idx][w] != LN_I && tag_q[b_idx][w] == b_tag) begin
        b_hit = 1'b1; b_way = WAY_W'(w); b_st = st_q[b_idx][w];
      end
    end
  end

  // victim: lowest invalid way, otherwise the oldest way
  always_comb begin
    v_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (age_q[a_idx][w] == WAY_W'(WAYS - 1)) v_way = WAY_W'(w);
    for (int w = WAYS - 1; w >= 0; w--)
      if (st_q[a_idx][w] == LN_I) v_way = WAY_W'(w);
    v_st  = st_q[a_idx][v_way];
    v_tag = tag_q[a_idx][v_way];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          st_q[s][w]  <= LN_I;
          tag_q[s][w] <= '0;
          age_q[s][w] <= WAY_W'(w);
        end
    end else begin
      if (we) begin
        st_q[w_idx][w_way]  <= w_st;
        tag_q[w_idx][w_way] <= w_tag;
      end
      if (touch)
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == t_way) age_q[t_idx][w] <= '0;
          else if (age_q[t_idx][w] < age_q[t_idx][t_way]) age_q[t_idx][w] <= age_q[t_idx][w] + 1'b1;
        end
    end
  end
endmodule

// File: rtl/mosi_line_ctrl.sv
module mosi_line_ctrl
  import mosi_ctrl_pkg::*;
#(
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  parameter int ADDR_W = 8,
  parameter int ACK_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_write,
  input  logic              cpu_spec,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_done,
  output logic              cpu_done_spec,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic [1:0]        bus_req_op,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic              bus_req_spec,
  input  logic              bus_resp_valid,
  input  logic [ACK_W-1:0]  bus_resp_acks,
  input  logic              inv_ack,
  input  logic              snp_valid,
  input  logic [1:0]        snp_op,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_resp_valid,
  output logic              snp_supply,
  output logic              snp_ack
);
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  ctl_st_e           st_q;
  logic [ADDR_W-1:0] rq_addr_q, wb_addr_q;
  logic              rq_wr_q, rq_spec_q, resp_seen_q;
  logic [WAY_W-1:0]  way_q;
  bus_op_e           op_q;
  logic [ACK_W-1:0]  need_q, got_q;
  logic              done_q, done_spec_q, sr_valid_q, sr_sup_q, sr_ack_q;

  logic              a_hit, b_hit;
  logic [WAY_W-1:0]  a_way, b_way, v_way;
  line_st_e          a_st, b_st, v_st, b_cur;
  logic [TAG_W-1:0]  v_tag;
  logic              we, touch;
  logic [IDX_W-1:0]  w_idx;
  logic [WAY_W-1:0]  w_way, t_way;
  logic [TAG_W-1:0]  w_tag;
  line_st_e          w_st;
  snoop_eff_t        seff;
  logic              quiet, hit_done, need_upg, miss, vict_dirty, fill_go, acks_done;

  mosi_line_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_idx(rq_addr_q[IDX_W-1:0]), .a_tag(rq_addr_q[ADDR_W-1:IDX_W]),
    .a_hit(a_hit), .a_way(a_way), .a_st(a_st),
    .v_way(v_way), .v_st(v_st), .v_tag(v_tag),
    .b_idx(snp_addr[IDX_W-1:0]), .b_tag(snp_addr[ADDR_W-1:IDX_W]),
    .b_hit(b_hit), .b_way(b_way), .b_st(b_st),
    .we(we), .w_idx(w_idx), .w_way(w_way), .w_tag(w_tag), .w_st(w_st),
    .touch(touch), .t_idx(rq_addr_q[IDX_W-1:0]), .t_way(t_way)
  );

  assign b_cur = b_hit ? b_st : LN_I;
  mosi_snoop_xlat u_xlat (.cur(b_cur), .op(snp_op), .eff(seff));

  // snoops own the store in their cycle; local updates wait for a quiet cycle
  assign quiet      = !snp_valid;
  assign hit_done   = (st_q == CS_LOOK) && quiet && a_hit && (!rq_wr_q || a_st == LN_M);
  assign need_upg   = (st_q == CS_LOOK) && quiet && a_hit && rq_wr_q && a_st != LN_M;
  assign miss       = (st_q == CS_LOOK) && quiet && !a_hit;
  assign vict_dirty = (v_st == LN_M) || (v_st == LN_O);
  assign fill_go    = (st_q == CS_FILL) && quiet;
  assign acks_done  = resp_seen_q && (got_q >= need_q);

  always_comb begin
    we    = 1'b0;
    w_idx = rq_addr_q[IDX_W-1:0];
    w_way = way_q;
    w_tag = rq_addr_q[ADDR_W-1:IDX_W];
    w_st  = rq_wr_q ? LN_M : LN_S;
    if (snp_valid) begin
      we    = b_hit && (seff.nxt != b_st);
      w_idx = snp_addr[IDX_W-1:0];
      w_way = b_way;
      w_tag = snp_addr[ADDR_W-1:IDX_W];
      w_st  = seff.nxt;
    end else if (miss && vict_dirty) begin
      we    = 1'b1;
      w_way = v_way;
      w_tag = v_tag;
      w_st  = LN_I;
    end else if (fill_go) begin
      we = 1'b1;
    end
  end

  assign touch = hit_done || fill_go;
  assign t_way = hit_done ? a_way : way_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= CS_IDLE; rq_addr_q <= '0; wb_addr_q <= '0; rq_wr_q <= 1'b0; rq_spec_q <= 1'b0;
      way_q <= '0; op_q <= OP_RDSH; need_q <= '0; got_q <= '0; resp_seen_q <= 1'b0;
    end else begin
      unique case (st_q)
        CS_IDLE: if (cpu_valid && cpu_ready) begin
          rq_addr_q <= cpu_addr; rq_wr_q <= cpu_write; rq_spec_q <= cpu_spec; st_q <= CS_LOOK;
        end
        CS_LOOK: if (hit_done) st_q <= CS_IDLE;
          else if (need_upg) begin
            op_q <= OP_INVAL; way_q <= a_way; st_q <= CS_REQ;
          end else if (miss) begin
            op_q      <= rq_wr_q ? OP_RDEX : OP_RDSH;
            way_q     <= v_way;
            wb_addr_q <= {v_tag, rq_addr_q[IDX_W-1:0]};
            st_q      <= vict_dirty ? CS_WBACK : CS_REQ;
          end
        CS_WBACK: if (bus_req_ready) st_q <= CS_REQ;
        CS_REQ: if (bus_req_ready) begin
          got_q <= '0; resp_seen_q <= 1'b0; st_q <= CS_WAIT;
        end
        CS_WAIT: begin
          if (inv_ack) got_q <= got_q + 1'b1;
          if (bus_resp_valid) begin resp_seen_q <= 1'b1; need_q <= bus_resp_acks; end
          if (acks_done) st_q <= CS_FILL;
        end
        CS_FILL: if (fill_go) st_q <= CS_IDLE;
        default: st_q <= CS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0; done_spec_q <= 1'b0; sr_valid_q <= 1'b0; sr_sup_q <= 1'b0; sr_ack_q <= 1'b0;
    end else begin
      done_q      <= hit_done || fill_go;
      done_spec_q <= rq_spec_q;
      sr_valid_q  <= snp_valid;
      sr_sup_q    <= snp_valid && seff.supply;
      sr_ack_q    <= snp_valid && seff.ack;
    end
  end

  assign cpu_ready      = (st_q == CS_IDLE) && !snp_valid && !sr_valid_q;
  assign cpu_done       = done_q;
  assign cpu_done_spec  = done_spec_q;
  assign bus_req_valid  = (st_q == CS_WBACK) || (st_q == CS_REQ);
  assign bus_req_op     = (st_q == CS_WBACK) ? OP_WBACK : op_q;
  assign bus_req_addr   = (st_q == CS_WBACK) ? wb_addr_q : rq_addr_q;
  assign bus_req_spec   = rq_spec_q;
  assign snp_resp_valid = sr_valid_q;
  assign snp_supply     = sr_sup_q;
  assign snp_ack        = sr_ack_q;
endmodule

// File: rtl/mosi_line_ctrl_chk.sv
module mosi_line_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_ready,
  input logic              cpu_done,
  input logic              bus_req_valid,
  input logic              bus_req_ready,
  input logic [1:0]        bus_req_op,
  input logic [ADDR_W-1:0] bus_req_addr,
  input logic              snp_valid,
  input logic [1:0]        snp_op,
  input logic              snp_resp_valid,
  input logic              snp_supply,
  input logic              snp_ack
);
  assert_snoop_answer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |=> snp_resp_valid);

  assert_stall_on_answer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    snp_resp_valid |-> !cpu_ready);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_req_ready |=> bus_req_valid && $stable(bus_req_op) && $stable(bus_req_addr));

  assert_inval_no_supply_R6: assert property (@(posedge clk) disable iff (!rst_n)
    snp_resp_valid && snp_supply |-> $past(snp_op) != 2'd2);

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

  assert_answer_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_supply || snp_ack) |-> snp_resp_valid);
endmodule

bind mosi_line_ctrl mosi_line_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .cpu_done(cpu_done),
  .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready), .bus_req_op(bus_req_op),
  .bus_req_addr(bus_req_addr), .snp_valid(snp_valid), .snp_op(snp_op),
  .snp_resp_valid(snp_resp_valid), .snp_supply(snp_supply), .snp_ack(snp_ack)
);

// File: tb/tb_mosi_line_ctrl.sv
module tb_mosi_line_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_valid = 0, cpu_write = 0, cpu_spec = 0, cpu_ready, cpu_done, cpu_done_spec;
  logic [7:0] cpu_addr = '0, bus_req_addr, snp_addr = '0;
  logic bus_req_valid, bus_req_ready = 0, bus_req_spec, bus_resp_valid = 0, inv_ack = 0;
  logic [1:0] bus_req_op, snp_op = '0;
  logic [2:0] bus_resp_acks = '0;
  logic snp_valid = 0, snp_resp_valid, snp_supply, snp_ack;
  int nchk = 0, nerr = 0, cycles = 0;

  always #4 clk = ~clk;

  mosi_line_ctrl dut (.*);

  typedef struct packed {
    logic       snoop; logic [1:0] op; logic [7:0] addr; logic spec; logic [1:0] acks;
    logic       e_wb;  logic [7:0] e_wba; logic e_req; logic [1:0] e_op;
    logic       e_sup; logic e_ack; logic [3:0] req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 8'h10, 1'b0, 2'd0, 1'b0, 8'h00, 1'b1, 2'd0, 1'b0, 1'b0, 4'd2},  // R2 read miss
    '{1'b1, 2'd0, 8'h10, 1'b0, 2'd0, 1'b0, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0, 4'd2},  // R2 shared: no supply
    '{1'b0, 2'd1, 8'h20, 1'b0, 2'd0, 1'b0, 8'h00, 1'b1, 2'd1, 1'b0, 1'b0, 4'd3},  // R3 write on I
    '{1'b0, 2'd1, 8'h20, 1'b0, 2'd0, 1'b0, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0, 4'd3},  // R3 write hit M
    '{1'b1, 2'd0, 8'h20, 1'b0, 2'd0, 1'b0, 8'h00, 1'b0, 2'd0, 1'b1, 1'b0, 4'd4},  // R4 M->O
    '{1'b1, 2'd0, 8'h20, 1'b0, 2'd0, 1'b0, 8'h00, 1'b0, 2'd0, 1'b1, 1'b0, 4'd4},  // R4 O keeps supplying
    '{1'b0, 2'd1, 8'h20, 1'b0, 2'd2, 1'b0, 8'h00, 1'b1, 2'd2, 1'b0, 1'b0, 4'd5},  // R5 O upgrade
    '{1'b1, 2'd0, 8'h20, 1'b0, 2'd0, 1'b0, 8'h00, 1'b0, 2'd0, 1'b1, 1'b0, 4'd4},  // R4 back to O
    '{1'b0, 2'd0, 8'h30, 1'b0, 2'd0, 1'b0, 8'h00, 1'b1, 2'd0, 1'b0, 1'b0, 4'd7},  // R7 clean victim
    '{1'b0, 2'd0, 8'h40, 1'b0, 2'd0, 1'b1, 8'h20, 1'b1, 2'd0, 1'b0, 1'b0, 4'd7},  // R7 dirty victim
    '{1'b1, 2'd0, 8'h20, 1'b0, 2'd0, 1'b0, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0, 4'd7},  // R7 evicted
    '{1'b0, 2'd1, 8'h30, 1'b1, 2'd0, 1'b0, 8'h00, 1'b1, 2'd2, 1'b0, 1'b0, 4'd8},  // R8 spec upgrade
    '{1'b1, 2'd1, 8'h30, 1'b0, 2'd0, 1'b0, 8'h00, 1'b0, 2'd0, 1'b1, 1'b1, 4'd8},  // R8 spec state kept
    '{1'b1, 2'd0, 8'h30, 1'b0, 2'd0, 1'b0, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0, 4'd11}, // R11
    '{1'b1, 2'd2, 8'h40, 1'b0, 2'd0, 1'b0, 8'h00, 1'b0, 2'd0, 1'b0, 1'b1, 4'd6},  // R6 inval S
    '{1'b0, 2'd0, 8'h40, 1'b0, 2'd0, 1'b0, 8'h00, 1'b1, 2'd0, 1'b0, 1'b0, 4'd6},  // R6 line gone
    '{1'b0, 2'd0, 8'h40, 1'b0, 2'd0, 1'b0, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0, 4'd12}, // R12 read hit
    '{1'b0, 2'd1, 8'h01, 1'b0, 2'd0, 1'b0, 8'h00, 1'b1, 2'd1, 1'b0, 1'b0, 4'd3},  // R3
    '{1'b1, 2'd1, 8'h01, 1'b0, 2'd0, 1'b0, 8'h00, 1'b0, 2'd0, 1'b1, 1'b1, 4'd6},  // R6 rdex on M
    '{1'b1, 2'd0, 8'h01, 1'b0, 2'd0, 1'b0, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0, 4'd11}  // R11
  };

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic do_snoop(input logic [1:0] op, input logic [7:0] a, output logic rv, output logic sup, output logic ack);
    @(negedge clk); snp_valid = 1; snp_op = op; snp_addr = a;
    @(negedge clk); snp_valid = 0;
    rv = snp_resp_valid; sup = snp_supply; ack = snp_ack;
    @(negedge clk);
  endtask

  task automatic do_local(input logic w, input logic [7:0] a, input logic sp, input int acks, input int hold,
                          output logic wb, output logic [7:0] wba, output logic rq, output logic [1:0] rop,
                          output logic rsp, output logic dsp, output logic done);
    wb = 0; wba = '0; rq = 0; rop = '0; rsp = 0; dsp = 0; done = 0;
    @(negedge clk); cpu_valid = 1; cpu_write = w; cpu_addr = a; cpu_spec = sp;
    while (!cpu_ready) @(negedge clk);
    @(negedge clk); cpu_valid = 0;
    for (int i = 0; i < 60 && !done; i++) begin
      if (cpu_done) begin done = 1; dsp = cpu_done_spec; end
      else if (bus_req_valid) begin
        logic [1:0] op0; logic [7:0] ad0;
        op0 = bus_req_op; ad0 = bus_req_addr;
        for (int h = 0; h < hold; h++) begin
          @(negedge clk);
          chk(bus_req_valid && bus_req_op == op0 && bus_req_addr == ad0, "R10", "request held", int'(bus_req_addr), int'(ad0));
        end
        if (bus_req_op == 2'd3) begin wb = 1; wba = bus_req_addr; end
        else begin rq = 1; rop = bus_req_op; rsp = bus_req_spec; end
        bus_req_ready = 1; @(negedge clk); bus_req_ready = 0;
        if (rq) begin
          bus_resp_valid = 1; bus_resp_acks = 3'(acks); @(negedge clk); bus_resp_valid = 0;
          for (int k = 0; k < acks; k++) begin inv_ack = 1; @(negedge clk); inv_ack = 0; end
        end
      end else @(negedge clk);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 20000) begin
        nerr++; nchk++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
      end
    end
  end

  initial begin
    logic rv, sup, ack, wb, rq, rsp, dsp, done;
    logic [7:0] wba; logic [1:0] rop;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(cpu_ready == 1, "R1", "cpu_ready", cpu_ready, 1);
    chk(bus_req_valid == 0, "R1", "bus_req_valid", bus_req_valid, 0);
    chk(cpu_done == 0 && snp_resp_valid == 0, "R1", "done/answer", cpu_done, 0);
    do_snoop(2'd1, 8'h10, rv, sup, ack);
    chk(rv && !sup && !ack, "R1", "snoop on empty cache", {sup, ack}, 0);

    for (int v = 0; v < NV; v++) begin
      string t;
      t = $sformatf("R%0d vec%0d", VECS[v].req, v);
      if (VECS[v].snoop) begin
        do_snoop(VECS[v].op, VECS[v].addr, rv, sup, ack);
        chk(rv == 1, t, "answer valid", rv, 1);
        chk(sup == VECS[v].e_sup, t, "supply", sup, VECS[v].e_sup);
        chk(ack == VECS[v].e_ack, t, "ack", ack, VECS[v].e_ack);
      end else begin
        do_local(VECS[v].op[0], VECS[v].addr, VECS[v].spec, int'(VECS[v].acks), 0, wb, wba, rq, rop, rsp, dsp, done);
        chk(done == 1, t, "completed", done, 1);
        chk(wb == VECS[v].e_wb, t, "write-back issued", wb, VECS[v].e_wb);
        if (VECS[v].e_wb) chk(wba == VECS[v].e_wba, t, "write-back addr", wba, VECS[v].e_wba);
        chk(rq == VECS[v].e_req, t, "bus request", rq, VECS[v].e_req);
        if (VECS[v].e_req) begin
          chk(rop == VECS[v].e_op, t, "bus op", rop, VECS[v].e_op);
          chk(rsp == VECS[v].spec, t, "bus spec", rsp, VECS[v].spec);
        end
        chk(dsp == VECS[v].spec, t, "done spec", dsp, VECS[v].spec);
      end
    end

    // R5: upgrade of Shared 0x40 waits for all three acks
    @(negedge clk); cpu_valid = 1; cpu_write = 1; cpu_addr = 8'h40; cpu_spec = 0;
    while (!cpu_ready) @(negedge clk);
    @(negedge clk); cpu_valid = 0;
    while (!bus_req_valid) @(negedge clk);
    chk(bus_req_op == 2'd2, "R5", "upgrade op", bus_req_op, 2);
    bus_req_ready = 1; @(negedge clk); bus_req_ready = 0;
    bus_resp_valid = 1; bus_resp_acks = 3'd3; @(negedge clk); bus_resp_valid = 0;
    for (int k = 0; k < 2; k++) begin inv_ack = 1; @(negedge clk); inv_ack = 0; end
    done = 0;
    for (int k = 0; k < 4; k++) begin if (cpu_done) done = 1; @(negedge clk); end
    chk(done == 0, "R5", "done before last ack", done, 0);
    inv_ack = 1; @(negedge clk); inv_ack = 0;
    done = 0;
    for (int k = 0; k < 5 && !done; k++) begin if (cpu_done) done = 1; else @(negedge clk); end
    chk(done == 1, "R5", "done after last ack", done, 1);
    do_snoop(2'd0, 8'h40, rv, sup, ack);
    chk(sup == 1, "R5", "line is M after upgrade", sup, 1);

    // R10: back-pressure on a read miss
    do_local(1'b0, 8'h05, 1'b0, 0, 5, wb, wba, rq, rop, rsp, dsp, done);
    chk(done && rq && rop == 2'd0, "R10", "stalled read completes", rop, 0);

    // R9: snoop and local request arrive together
    @(negedge clk); snp_valid = 1; snp_op = 2'd0; snp_addr = 8'h77;
    cpu_valid = 1; cpu_write = 0; cpu_addr = 8'h05; cpu_spec = 0;
    #1 chk(cpu_ready == 0, "R9", "ready during snoop", cpu_ready, 0);
    @(negedge clk); snp_valid = 0;
    chk(snp_resp_valid == 1, "R9", "answer next cycle", snp_resp_valid, 1);
    chk(cpu_ready == 0, "R9", "ready during answer", cpu_ready, 0);
    @(negedge clk);
    chk(cpu_ready == 1, "R9", "ready after answer", cpu_ready, 1);
    @(negedge clk); cpu_valid = 0;
    done = 0;
    for (int k = 0; k < 6 && !done; k++) begin if (cpu_done) done = 1; else @(negedge clk); end
    chk(done == 1, "R12", "hit after snoop", done, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule